// File: doc/BRIEF.md
# Byte Multiplier with Signed Correction Sequencer

This unit multiplies two 8-bit operands for a small processor datapath. The array inside it is unsigned only. An unsigned request is accepted on a start strobe, and the 16-bit product is placed in a high/low pair of product registers by that same clock edge. A one-cycle done pulse follows in the next cycle.

A signed request uses the same unsigned array. A short sequencer then turns the result into a two's-complement product. For each operand whose sign bit is set, it takes the other operand away from the high product byte, modulo 256. The sequencer always runs a fixed number of steps, whatever the sign bits are, so a signed result always takes the same time.

A separate status-flag register sits beside the multiplier. It changes only through its own write port. The multiplier never touches it.

Top module: `byte_mult_seq`

## Requirements
- R1: An unsigned request with operands A and B leaves A*B in the product registers, with bits 15:8 in `prod_hi_o` and bits 7:0 in `prod_lo_o`.
- R2: An unsigned request sampled at clock edge E0 gives `done_o` high in the cycle right after E0. `busy_o` stays low throughout.
- R3: A signed request leaves the 16-bit two's-complement product of A and B in the product registers. Both operands are read as signed 8-bit values.
- R4: A signed request sampled at edge E0 gives `busy_o` high, with `done_o` low, for the next 5 cycles. `done_o` then rises in the 6th cycle after E0, and `busy_o` is low in that cycle.
- R5: The sign correction works as follows. If B[7]=1, A is subtracted mod 256 from the high byte. If A[7]=1, B is subtracted mod 256 from the high byte. Both corrections apply when both bits are set. The low byte is never altered by a correction.
- R6: A start strobe that arrives while `busy_o` is high is ignored. It produces no extra result and no extra done pulse.
- R7: Operands are captured with the start strobe. Changing `opa_i` and `opb_i` during a signed sequence does not change the result.
- R8: `done_o` is high for exactly one cycle per accepted request. The product registers then hold their value until the next accepted request.
- R9: `flags_o` changes only when `flags_we_i` is high, and then loads `flags_d_i`. Multiply requests never alter it.
- R10: After reset, `prod_hi_o`, `prod_lo_o`, `flags_o`, `busy_o` and `done_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request strobe; taken only while `busy_o` is low |
| signed_i | input | 1 | 1 selects a signed multiply, 0 an unsigned one |
| opa_i | input | 8 | Operand A |
| opb_i | input | 8 | Operand B |
| busy_o | output | 1 | A signed sequence is in progress |
| done_o | output | 1 | One-cycle pulse when the product registers hold the final result |
| prod_hi_o | output | 8 | High product byte |
| prod_lo_o | output | 8 | Low product byte |
| flags_we_i | input | 1 | Write enable of the status-flag register |
| flags_d_i | input | 4 | Data for the status-flag register |
| flags_o | output | 4 | Status-flag register contents |

## Verification
Some internal faults show up quickly at the ports. A sequencer that skips or repeats a step moves `done_o` away from the 6th cycle after the start, and the fault is seen in the very cycle the pulse is due. A wrongly latched sign bit, or a subtraction of the wrong operand, leaves the high byte wrong at the done pulse. The low byte stays right in that case, so the high byte is compared in every case. Operand capture that follows the live inputs shows up only when the inputs change in mid-sequence, so the bench does exactly that. A start that is wrongly accepted while busy shows up as a done pulse with no result expected.

// File: rtl/byte_mult_seq.sv
module byte_mult_seq #(
  parameter int W  = 8,
  parameter int FW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          signed_i,
  input  logic [W-1:0]  opa_i,
  input  logic [W-1:0]  opb_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [W-1:0]  prod_hi_o,
  output logic [W-1:0]  prod_lo_o,
  input  logic          flags_we_i,
  input  logic [FW-1:0] flags_d_i,
  output logic [FW-1:0] flags_o
);
  localparam int PW = 2 * W;

  typedef enum logic [2:0] {
    S_IDLE, S_MUL, S_TSTB, S_SUBA, S_TSTA, S_SUBB, S_DONE
  } st_t;

  st_t           st_q;
  logic [W-1:0]  a_q, b_q;
  logic          neg_q;
  logic          accept;
  logic [W-1:0]  mx, my;
  logic [PW-1:0] prod;

  assign busy_o = (st_q != S_IDLE) && (st_q != S_DONE);
  assign done_o = (st_q == S_DONE);
  assign accept = start_i && !busy_o;

  assign mx   = (st_q == S_MUL) ? a_q : opa_i;
  assign my   = (st_q == S_MUL) ? b_q : opb_i;
  assign prod = PW'(mx) * PW'(my);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      a_q       <= '0;
      b_q       <= '0;
      neg_q     <= 1'b0;
      prod_hi_o <= '0;
      prod_lo_o <= '0;
    end else if (accept) begin
      a_q <= opa_i;
      b_q <= opb_i;
      if (signed_i) begin
        st_q <= S_MUL;
      end else begin
        {prod_hi_o, prod_lo_o} <= prod;
        st_q <= S_DONE;
      end
    end else begin
      case (st_q)
        S_MUL: begin
          {prod_hi_o, prod_lo_o} <= prod;
          st_q <= S_TSTB;
        end
        S_TSTB: begin
          neg_q <= b_q[W-1];
          st_q  <= S_SUBA;
        end
        S_SUBA: begin
          if (neg_q) prod_hi_o <= prod_hi_o - a_q;
          st_q <= S_TSTA;
        end
        S_TSTA: begin
          neg_q <= a_q[W-1];
          st_q  <= S_SUBB;
        end
        S_SUBB: begin
          if (neg_q) prod_hi_o <= prod_hi_o - b_q;
          st_q <= S_DONE;
        end
        S_DONE:  st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          flags_o <= '0;
    else if (flags_we_i) flags_o <= flags_d_i;
  end

  AST_UNS_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && !signed_i) |=>
      (done_o && {prod_hi_o, prod_lo_o} == PW'($past(opa_i)) * PW'($past(opb_i)))); // R1
  AST_SGN_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_SUBB) |=>
      ($signed({prod_hi_o, prod_lo_o}) == PW'($signed(a_q) * $signed(b_q)))); // R3
  AST_BUSY_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !done_o); // R4
  AST_LO_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_TSTB || st_q == S_SUBA || st_q == S_TSTA || st_q == S_SUBB) |=>
      $stable(prod_lo_o)); // R5
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> ($stable(a_q) && $stable(b_q))); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> !done_o); // R8
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !flags_we_i |=> $stable(flags_o)); // R9
endmodule

// File: tb/byte_mult_seq_test.sv
module byte_mult_seq_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0, signed_i = 1'b0;
  logic [7:0] opa_i = '0, opb_i = '0;
  logic       busy_o, done_o;
  logic [7:0] prod_hi_o, prod_lo_o;
  logic       flags_we_i = 1'b0;
  logic [3:0] flags_d_i = '0;
  logic [3:0] flags_o;

  int  nchk = 0, nfail = 0;
  bit  finished = 0;
  logic [16:0] exp_q[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  byte_mult_seq uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .signed_i(signed_i),
    .opa_i(opa_i), .opb_i(opb_i), .busy_o(busy_o), .done_o(done_o),
    .prod_hi_o(prod_hi_o), .prod_lo_o(prod_lo_o),
    .flags_we_i(flags_we_i), .flags_d_i(flags_d_i), .flags_o(flags_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  task automatic issue(input logic [7:0] a, input logic [7:0] b, input bit sgn);
    logic signed [7:0] sa, sb;
    logic [15:0] e;
    while (busy_o) @(negedge clk);
    sa = a; sb = b;
    e = sgn ? 16'(sa * sb) : 16'(a) * 16'(b);
    exp_q.push_back({sgn, e});
    start_i = 1'b1; signed_i = sgn; opa_i = a; opb_i = b;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && done_o) begin
      if (exp_q.size() == 0) begin
        check(0, "R6 unexpected done", 1, 0);
      end else begin
        logic [16:0] it;
        it = exp_q.pop_front();
        check({prod_hi_o, prod_lo_o} == it[15:0], it[16] ? "R3/R5 signed product" : "R1 unsigned product",
              {prod_hi_o, prod_lo_o}, it[15:0]);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    logic [15:0] held;
    repeat (3) @(negedge clk);
    // R10 reset state
    check({prod_hi_o, prod_lo_o, flags_o, busy_o, done_o} == 0, "R10 reset",
          {prod_hi_o, prod_lo_o, flags_o, busy_o, done_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 flag write
    flags_we_i = 1'b1; flags_d_i = 4'hA;
    @(negedge clk);
    flags_we_i = 1'b0; flags_d_i = 4'h5;
    check(flags_o == 4'hA, "R9 flag load", flags_o, 4'hA);

    // R2 unsigned latency
    issue(8'd13, 8'd11, 0);
    check(done_o == 1 && busy_o == 0, "R2 unsigned done timing", {done_o, busy_o}, 2'b10);

    // R4 signed latency
    @(negedge clk);
    issue(8'h9C, 8'h27, 1);
    for (int k = 1; k <= 5; k++) begin
      check(busy_o == 1 && done_o == 0, "R4 signed busy window", {busy_o, done_o}, 2'b10);
      @(negedge clk);
    end
    check(done_o == 1 && busy_o == 0, "R4 signed done timing", {done_o, busy_o}, 2'b10);

    // R8 product holds, done is a single pulse
    held = {prod_hi_o, prod_lo_o};
    repeat (3) @(negedge clk);
    check({prod_hi_o, prod_lo_o} == held, "R8 product hold", {prod_hi_o, prod_lo_o}, held);
    check(done_o == 0, "R8 done single pulse", done_o, 0);

    // R6/R7: start while busy ignored, operand changes ignored
    issue(8'h85, 8'h3C, 1);
    start_i = 1'b1; signed_i = 1'b0; opa_i = 8'hFF; opb_i = 8'hFF;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < 3; k++) begin
      opa_i = 8'(k * 77 + 1); opb_i = 8'(k * 31 + 200);
      @(negedge clk);
    end
    while (!done_o) @(negedge clk);
    @(negedge clk);
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0 && done_o == 0, "R6 busy start ignored", exp_q.size(), 0);

    // R5 sign-correction corners
    issue(8'h80, 8'h80, 1);
    issue(8'hFF, 8'hFF, 1);
    issue(8'h7F, 8'h80, 1);
    issue(8'h80, 8'hFF, 1);
    issue(8'h00, 8'h80, 1);
    issue(8'h7F, 8'h7F, 1);

    // R1 exhaustive unsigned sweep
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        issue(8'(a), 8'(b), 0);

    // R3 signed sweep: every A against 32 spread B values (0,7F,80,FF included)
    for (int j = 0; j < 32; j++)
      for (int a = 0; a < 256; a++)
        issue(8'(a), 8'(j * 8 + (j % 8)), 1);

    while (busy_o || done_o) @(negedge clk);
    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R8 all results delivered", exp_q.size(), 0);
    check(flags_o == 4'hA, "R9 flags untouched by multiply", flags_o, 4'hA);
    finish_run();
  end
endmodule